// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A 32-pin general-purpose I/O bank behind a small word-addressed register port. Every pin has an output value, a drive-enable (direction) bit, a pull-disable bit and an alternate-function hand-off bit. Software can change the output-value and direction registers atomically through write-one-to-set and write-one-to-clear aliases, so no read-modify-write is needed. When a pin is an input with pulls enabled, its output-value bit chooses between pull-up and pull-down. The pull choice is presented as two per-pin control vectors for the pad ring.

Pad inputs pass through a two-flop synchronizer. The synchronized value is used both for readback of input pins and for edge detection. Each pin has separate rising-edge and falling-edge enable masks. A detected, enabled edge latches a sticky status bit, and software releases it by writing one to the matching bit of a clear alias. A single interrupt line is high while any status bit is pending.

Register access has no handshake. A write takes effect on the clock edge that samples `bus_wr`. A read presents its word on `bus_rdata` after the edge that samples `bus_rd`, and the word holds until the next read. The block is a single datapath and has no control state machine. The only sequencing is the synchronizer pipeline: pad, stage 1, stage 2, previous-value flop, and then the status register.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every readable register (offsets 0x00, 0x0C, 0x10, 0x20, 0x40, 0x44, 0x48) reads zero, `irq` and `pad_oe` are zero, and `pull_dn_en` is all ones, because every pin resets as an input with pulls on and a value bit of 0.
- R2: A write to 0x00 loads the output-value register. A write to 0x04 sets exactly the bits written as one, and a write to 0x08 clears exactly those bits. All other bits are unchanged. `pad_out` equals the output-value register.
- R3: The direction register at 0x10 is loaded by a write to 0x10, set-by-one through 0x14 and cleared-by-one through 0x18. A direction bit of 1 marks an output pin.
- R4: A read of 0x00 returns the register bit for output pins and the synchronized pad value for input pins. A pad change is visible to a read issued two clock edges after the change.
- R5: For each pin, `pull_up_en` is 1 when the pin is an input, its pull-disable bit (0x0C) is 0 and its value bit is 1. `pull_dn_en` is 1 under the same conditions with a value bit of 0. Both are 0 when pull-disable is 1 or the pin is an output.
- R6: The alternate-function register (0x20) appears on `alt_sel`. A pin whose bit is 1 there has `pad_oe` forced to 0. Otherwise `pad_oe` equals the direction bit.
- R7: With the pin's bit set in the rising mask (0x40), a synchronized low-to-high transition sets that pin's bit in status (0x48). Transitions on pins with no mask bit set leave status unchanged.
- R8: With the pin's bit set in the falling mask (0x44), a high-to-low transition sets the status bit. A pin enabled in both masks latches on either transition.
- R9: Writing 0x4C clears exactly the status bits written as one, so all ones clears everything. If a new edge and a clear for the same bit occur in the same cycle, the bit stays set.
- R10: `irq` is 1 exactly while any status bit is 1.
- R11: Reads of 0x04, 0x08, 0x14, 0x18 and 0x4C, and of the unused offsets, return zero. Writes to unused offsets (0x1C, 0x24–0x3C) and to the status offset 0x48 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; data appears after the sampling edge |
| bus_addr | input | 7 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held until the next read |
| pad_in | input | 32 | Asynchronous pad input values |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Drive enable per pin |
| pull_up_en | output | 32 | Pull-up request per pin |
| pull_dn_en | output | 32 | Pull-down request per pin |
| alt_sel | output | 32 | Alternate-function hand-off per pin |
| irq | output | 1 | Combined edge interrupt |

## Verification
Set and clear aliases are exercised with masks that overlap bits already set and bits already clear. This separates true per-bit set/clear behaviour from a plain load or a toggle. Data readback is tried with a half-output, half-input direction split and a distinct pad pattern, so a swap between pad value and register value shows up. Edge stimulus drives one pin enabled for rising only, one for falling only, one for both and one enabled for neither, through both transitions. That shows whether each mask gates the correct polarity. A clear written in the exact cycle an edge is detected tells whether the edge or the clear takes priority.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned IDX_W = 5;

    // word index = byte offset / 4
    typedef enum logic [IDX_W-1:0] {
        RI_VAL     = 5'd0,
        RI_VAL_SET = 5'd1,
        RI_VAL_CLR = 5'd2,
        RI_NOPULL  = 5'd3,
        RI_DRV     = 5'd4,
        RI_DRV_SET = 5'd5,
        RI_DRV_CLR = 5'd6,
        RI_ALT     = 5'd8,
        RI_RISE    = 5'd16,
        RI_FALL    = 5'd17,
        RI_PEND    = 5'd18,
        RI_ACK     = 5'd19
    } reg_idx_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] val_q,
    output logic [WIDTH-1:0] drv_q,
    output logic [WIDTH-1:0] nopull_q,
    output logic [WIDTH-1:0] alt_q,
    output logic [WIDTH-1:0] rise_q,
    output logic [WIDTH-1:0] fall_q,
    output logic [WIDTH-1:0] ack_mask
);

    logic [WIDTH-1:0] val_d, drv_d, nopull_d, alt_d, rise_d, fall_d;

    always_comb begin
        val_d    = val_q;
        drv_d    = drv_q;
        nopull_d = nopull_q;
        alt_d    = alt_q;
        rise_d   = rise_q;
        fall_d   = fall_q;
        ack_mask = '0;
        if (wr_en) begin
            unique case (reg_idx_e'(wr_idx))
                RI_VAL:     val_d    = wr_data;
                RI_VAL_SET: val_d    = val_q | wr_data;
                RI_VAL_CLR: val_d    = val_q & ~wr_data;
                RI_NOPULL:  nopull_d = wr_data;
                RI_DRV:     drv_d    = wr_data;
                RI_DRV_SET: drv_d    = drv_q | wr_data;
                RI_DRV_CLR: drv_d    = drv_q & ~wr_data;
                RI_ALT:     alt_d    = wr_data;
                RI_RISE:    rise_d   = wr_data;
                RI_FALL:    fall_d   = wr_data;
                RI_ACK:     ack_mask = wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q    <= '0;
            drv_q    <= '0;
            nopull_q <= '0;
            alt_q    <= '0;
            rise_q   <= '0;
            fall_q   <= '0;
        end else begin
            val_q    <= val_d;
            drv_q    <= drv_d;
            nopull_q <= nopull_d;
            alt_q    <= alt_d;
            rise_q   <= rise_d;
            fall_q   <= fall_d;
        end
    end

    // R2
    val_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == RI_VAL_SET) |=> ((val_q & $past(wr_data)) == $past(wr_data)));

    // R2
    val_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == RI_VAL_CLR) |=> ((val_q & $past(wr_data)) == '0));

    // R3
    drv_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == RI_DRV_CLR) |=> ((drv_q & $past(wr_data)) == '0));

    // R11
    unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx == 5'd7 || wr_idx == RI_PEND)) |=> ($stable(val_q) && $stable(drv_q) && $stable(alt_q)));

endmodule

// File: rtl/gpio_bank_edge.sv
module gpio_bank_edge #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] ack_mask,
    output logic [WIDTH-1:0] pend_q
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;

    always_comb begin
        hit = (pin_sync & ~prev_q & rise_en) | (~pin_sync & prev_q & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend_q <= '0;
        end else begin
            prev_q <= pin_sync;
            pend_q <= (pend_q & ~ack_mask) | hit;
        end
    end

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & ~$past(hit)) == '0));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & $past(ack_mask & ~hit)) == '0));

    // R9
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pend_q & $past(hit)) == '0));

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH       = 32,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pull_up_en,
    output logic [WIDTH-1:0]  pull_dn_en,
    output logic [WIDTH-1:0]  alt_sel,
    output logic              irq
);

    logic [IDX_W-1:0] idx;
    logic [WIDTH-1:0] val_q, drv_q, nopull_q, alt_q, rise_q, fall_q, ack_mask;
    logic [WIDTH-1:0] pin_sync, pend_q, rd_mux;

    assign idx = bus_addr[ADDR_W-1:2];

    gpio_bank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    gpio_bank_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .wr_idx   (idx),
        .wr_data  (bus_wdata),
        .val_q    (val_q),
        .drv_q    (drv_q),
        .nopull_q (nopull_q),
        .alt_q    (alt_q),
        .rise_q   (rise_q),
        .fall_q   (fall_q),
        .ack_mask (ack_mask)
    );

    gpio_bank_edge #(.WIDTH(WIDTH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .ack_mask (ack_mask),
        .pend_q   (pend_q)
    );

    always_comb begin
        unique case (reg_idx_e'(idx))
            RI_VAL:    rd_mux = (drv_q & val_q) | (~drv_q & pin_sync);
            RI_NOPULL: rd_mux = nopull_q;
            RI_DRV:    rd_mux = drv_q;
            RI_ALT:    rd_mux = alt_q;
            RI_RISE:   rd_mux = rise_q;
            RI_FALL:   rd_mux = fall_q;
            RI_PEND:   rd_mux = pend_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    assign pad_out    = val_q;
    assign pad_oe     = drv_q & ~alt_q;
    assign pull_up_en = ~drv_q & ~nopull_q & val_q;
    assign pull_dn_en = ~drv_q & ~nopull_q & ~val_q;
    assign alt_sel    = alt_q;
    assign irq        = |pend_q;

    // R6
    alt_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idx == RI_ALT) |=> ((pad_oe & $past(bus_wdata)) == '0));

    // R5
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_up_en & pull_dn_en) == '0) && ((pull_up_en & pad_oe) == '0));

endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe, pull_up_en, pull_dn_en, alt_sel;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
        .alt_sel(alt_sel), .irq(irq)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compares read results against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read data %h (no expected item)", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                tests++;
                if (bus_rdata !== e) begin
                    fails++;
                    $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        tests++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(7'h00, 32'h0, "R1 value");
        rd(7'h0C, 32'h0, "R1 nopull");
        rd(7'h10, 32'h0, "R1 dir");
        rd(7'h20, 32'h0, "R1 alt");
        rd(7'h40, 32'h0, "R1 rise");
        rd(7'h44, 32'h0, "R1 fall");
        rd(7'h48, 32'h0, "R1 status");
        chk({31'b0, irq}, 32'h0, "R1 irq");
        chk(pad_oe, 32'h0, "R1 pad_oe");
        chk(pull_dn_en, 32'hFFFF_FFFF, "R1 pull_dn_en");

        // R3 direction set, R2 value load/set/clear
        wr(7'h14, 32'hFFFF_FFFF);
        rd(7'h10, 32'hFFFF_FFFF, "R3 dir set");
        wr(7'h00, 32'hA5A5_0000);
        wr(7'h04, 32'h0000_000F);
        rd(7'h00, 32'hA5A5_000F, "R2 value set");
        wr(7'h08, 32'hA000_0001);
        rd(7'h00, 32'h05A5_000E, "R2 value clear");
        chk(pad_out, 32'h05A5_000E, "R2 pad_out");
        chk(pad_oe, 32'hFFFF_FFFF, "R3 pad_oe all out");

        // R3 direction clear, R4 mixed readback
        wr(7'h18, 32'hFFFF_0000);
        rd(7'h10, 32'h0000_FFFF, "R3 dir clear");
        @(negedge clk); pad_in = 32'h1234_5678;
        idle(3);
        rd(7'h00, 32'h1234_000E, "R4 mixed readback");

        // R5 pulls
        wr(7'h0C, 32'h00FF_0000);
        chk(pull_up_en, 32'h0500_0000, "R5 pull_up_en");
        chk(pull_dn_en, 32'hFA00_0000, "R5 pull_dn_en");

        // R6 alternate function
        wr(7'h20, 32'h0000_0003);
        rd(7'h20, 32'h0000_0003, "R6 alt read");
        chk(alt_sel, 32'h0000_0003, "R6 alt_sel");
        chk(pad_oe, 32'h0000_FFFC, "R6 pad_oe gated");

        // R11 alias reads zero, unused/status writes ignored
        rd(7'h04, 32'h0, "R11 set alias read");
        rd(7'h08, 32'h0, "R11 clr alias read");
        rd(7'h14, 32'h0, "R11 dir set read");
        rd(7'h18, 32'h0, "R11 dir clr read");
        rd(7'h4C, 32'h0, "R11 ack read");
        wr(7'h1C, 32'hFFFF_FFFF);
        wr(7'h30, 32'hFFFF_FFFF);
        wr(7'h48, 32'hFFFF_FFFF);
        rd(7'h10, 32'h0000_FFFF, "R11 dir after unused writes");
        rd(7'h20, 32'h0000_0003, "R11 alt after unused writes");
        rd(7'h48, 32'h0, "R11 status not writable");
        rd(7'h30, 32'h0, "R11 unused read");

        // edge setup: all inputs, pads low
        @(negedge clk); pad_in = 32'h0;
        wr(7'h18, 32'hFFFF_FFFF);
        idle(4);
        wr(7'h40, 32'h0000_0005);
        wr(7'h44, 32'h0000_0006);
        rd(7'h48, 32'h0, "R7 no status before edges");

        // R7 rising on bits 0 and 2; bits 1 (fall only) and 3 (none) ignored
        @(negedge clk); pad_in = 32'h0000_000F;
        idle(4);
        rd(7'h48, 32'h0000_0005, "R7 rising status");
        chk({31'b0, irq}, 32'h1, "R10 irq high");

        // R8 falling on bits 1 and 2
        @(negedge clk); pad_in = 32'h0;
        idle(4);
        rd(7'h48, 32'h0000_0007, "R8 falling status");

        // R9 partial then full clear
        wr(7'h4C, 32'h0000_0001);
        rd(7'h48, 32'h0000_0006, "R9 partial clear");
        wr(7'h4C, 32'hFFFF_FFFF);
        rd(7'h48, 32'h0, "R9 clear all");
        chk({31'b0, irq}, 32'h0, "R10 irq low");

        // R9 edge and clear in same cycle: edge wins
        @(negedge clk); pad_in = 32'h0000_0001;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 32'h0000_0001;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(7'h48, 32'h0000_0001, "R9 edge wins over clear");
        chk({31'b0, irq}, 32'h1, "R10 irq after collision");

        idle(3);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule